// File: doc/BRIEF.md
# EDO DRAM Device Strobe and I/O Control

This block is the device side of a DRAM with extended-data-out page mode, holding a small storage array. A memory controller drives a row strobe, two byte-lane column strobes, a write enable, an output enable and a 9-bit multiplexed address bus. The row address is taken when the row strobe falls. The column address is taken when the merged internal column strobe falls. Each column strobe guards one byte lane of the 16-bit data path, so reads and writes can act on one byte or on both.

All strobe inputs are active low. They are sampled against a fast oversampling clock through a synchronizer chain, and every edge is found synchronously, so the block is fully synthesizable. The address and write data pass through a pipeline of the same depth, which keeps them aligned with the strobes. Read data sits in an output register. It stays driven after the column strobes rise for as long as the row strobe and output enable stay low and write enable stays high. A per-byte drive enable stands in for the tri-state pads.

Top module: `edo_dram_ctl`

## Requirements
- R1: The internal column strobe becomes active when the first of the two byte strobes falls and inactive only when the last one rises. A byte strobe that toggles while the other stays low latches no new column.
- R2: The low byte strobe (`lcas_ni`) governs data bits 7:0 and drive enable bit 0. The high byte strobe (`ucas_ni`) governs bits 15:8 and drive enable bit 1. A write changes only the lanes whose strobe is low.
- R3: Write data is captured at the later of the write enable falling edge and the byte strobe falling edge. A later change of the data input during the same strobe-low period is not written.
- R4: After the column strobes rise with the row strobe low, output enable low and write enable high, the output data and the drive enables hold their values.
- R5: The row address is taken when the row strobe falls, and the column address when the internal column strobe falls. The array word is selected by the low `ROW_USE` bits of the row and the low `COL_USE` bits of the column.
- R6: The drive enables are zero while output enable is high, while write enable is low, and while the row strobe and internal column strobe are both high. Drive stays off after precharge until a new read access.
- R7: Each new fall of the internal column strobe while the row strobe stays low starts a fresh access in the same row and reloads the output register.
- R8: After reset the drive enables and the output data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| ucas_ni | input | 1 | High byte column strobe, active low |
| lcas_ni | input | 1 | Low byte column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (9) | Multiplexed row/column address |
| dq_i | input | 2*LANE_W (16) | Write data |
| dq_o | output | 2*LANE_W (16) | Read data |
| dq_oe_o | output | 2 | Per-byte output drive enable |

## Verification
The bench builds the block with its defaults: a 9-bit address bus, 8-bit lanes, two synchronizer stages and 4 row and 4 column bits in use. That gives 256 words. Any row and column the bench picks fits, so distinct values can sit in the same column of two rows and in several columns of one row. Row selection, page-mode reloads and merged-strobe behaviour can then be told apart by data value alone. The short synchronizer keeps every strobe sequence within a handful of cycles.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int unsigned LANES = 2;

  // all fields active low
  typedef struct packed {
    logic ras;
    logic ucas;
    logic lcas;
    logic we;
    logic oe;
  } strobe_t;

  localparam int unsigned STROBE_W = $bits(strobe_t);
endpackage

// File: rtl/edo_sync_pipe.sv
module edo_sync_pipe #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stg_q [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stg
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= RST_VAL;
          else if (i == 0) stg_q[i] <= d_i;
          else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
        end
      end
      assign q_o = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/edo_strobe_decode.sv
module edo_strobe_decode
  import edo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  strobe_t          strb_i,
  output logic             ras_low_o,
  output logic             ras_fall_o,
  output logic             cas_act_o,
  output logic             cas_fall_o,
  output logic             we_fall_o,
  output logic             precharge_o,
  output logic [LANES-1:0] lane_low_o,
  output logic [LANES-1:0] lane_fall_o
);
  strobe_t prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= strobe_t'('1);
    else prev_q <= strb_i;
  end

  logic [LANES-1:0] prev_lane_low;
  logic             prev_cas_act;

  // lane 0 = low byte, lane 1 = high byte
  assign lane_low_o    = {~strb_i.ucas, ~strb_i.lcas};
  assign prev_lane_low = {~prev_q.ucas, ~prev_q.lcas};
  assign lane_fall_o   = lane_low_o & ~prev_lane_low;

  // first fall activates, last rise releases
  assign cas_act_o    = |lane_low_o;
  assign prev_cas_act = |prev_lane_low;
  assign cas_fall_o   = cas_act_o & ~prev_cas_act;

  assign ras_low_o   = ~strb_i.ras;
  assign ras_fall_o  = prev_q.ras & ~strb_i.ras;
  assign we_fall_o   = prev_q.we & ~strb_i.we;
  assign precharge_o = strb_i.ras & ~cas_act_o;
endmodule

// File: rtl/edo_cell_array.sv
module edo_cell_array #(
  parameter int unsigned AW = 8,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES = 2,
  localparam int unsigned DW = LANE_W * LANES,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] wr_lane_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  generate
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      always_ff @(posedge clk_i) begin
        if (wr_lane_i[b]) mem_q[addr_i][b*LANE_W +: LANE_W] <= wdata_i[b*LANE_W +: LANE_W];
      end
    end
  endgenerate

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/edo_dram_ctl.sv
module edo_dram_ctl
  import edo_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ROW_USE = 4,
  parameter int unsigned COL_USE = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned IDX_W = ROW_USE + COL_USE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              ucas_ni,
  input  logic              lcas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe_o
);
  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  strobe_t           strb_raw, strb_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] dq_s;

  assign strb_raw = '{ras: ras_ni, ucas: ucas_ni, lcas: lcas_ni, we: we_ni, oe: oe_ni};

  edo_sync_pipe #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL({STROBE_W{1'b1}})) u_strb_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(strb_raw), .q_o(strb_s)
  );

  // same depth keeps address and data aligned with strobes
  edo_sync_pipe #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({addr_i, dq_i}), .q_o({addr_s, dq_s})
  );

  logic             ras_low, ras_fall, cas_act, cas_fall, we_fall, precharge;
  logic [LANES-1:0] lane_low, lane_fall;

  edo_strobe_decode u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .strb_i(strb_s),
    .ras_low_o(ras_low), .ras_fall_o(ras_fall), .cas_act_o(cas_act),
    .cas_fall_o(cas_fall), .we_fall_o(we_fall), .precharge_o(precharge),
    .lane_low_o(lane_low), .lane_fall_o(lane_fall)
  );

  logic               we_hi, oe_hi;
  logic [ROW_USE-1:0] row_q, row_eff;
  logic [COL_USE-1:0] col_q, col_eff;
  logic [IDX_W-1:0]   idx;
  logic [LANES-1:0]   wr_lane, byte_en_q;
  logic [DATA_W-1:0]  rdata, rdata_q;
  logic               rd_trig;

  assign we_hi = strb_s.we;
  assign oe_hi = strb_s.oe;

  assign row_eff = ras_fall ? addr_s[ROW_USE-1:0] : row_q;
  assign col_eff = cas_fall ? addr_s[COL_USE-1:0] : col_q;
  assign idx     = {row_eff, col_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (ras_fall) row_q <= addr_s[ROW_USE-1:0];
      if (cas_fall && ras_low) col_q <= addr_s[COL_USE-1:0];
    end
  end

  // capture on the later of lane strobe fall and write enable fall
  generate
    for (genvar b = 0; b < LANES; b++) begin : g_wr
      assign wr_lane[b] = ras_low & ((lane_fall[b] & ~we_hi) | (we_fall & lane_low[b]));
    end
  endgenerate

  edo_cell_array #(.AW(IDX_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk_i(clk_i), .wr_lane_i(wr_lane), .addr_i(idx), .wdata_i(dq_s), .rdata_o(rdata)
  );

  assign rd_trig = ras_low & we_hi & (|lane_fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_en_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (precharge || !we_hi) byte_en_q <= '0;
      else if (cas_fall && ras_low) byte_en_q <= lane_low;
      else if (rd_trig) byte_en_q <= byte_en_q | lane_fall;
      if (rd_trig) rdata_q <= rdata;
    end
  end

  assign dq_o    = rdata_q;
  assign dq_oe_o = byte_en_q & {LANES{we_hi & ~oe_hi & ~precharge}};
endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk #(
  parameter int unsigned ROW_USE = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ras_low,
  input logic               cas_act,
  input logic               we_hi,
  input logic               oe_hi,
  input logic [ROW_USE-1:0] row_q,
  input logic [DATA_W-1:0]  dq_o,
  input logic [1:0]         dq_oe_o
);
  AST_OE_BLOCKS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_hi |-> dq_oe_o == 2'b00); // R6

  AST_WE_BLOCKS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_hi |-> dq_oe_o == 2'b00); // R6

  AST_PRECHARGE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_low && !cas_act) |-> dq_oe_o == 2'b00); // R6

  AST_EDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_low && !oe_hi && we_hi && !cas_act && $past(cas_act) &&
     $past(ras_low && !oe_hi && we_hi))
    |-> (dq_oe_o == $past(dq_oe_o) && $stable(dq_o))); // R4

  AST_ROW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_low && $past(ras_low) && $past(ras_low, 2)) |-> $stable(row_q)); // R5
endmodule

bind edo_dram_ctl edo_dram_chk #(.ROW_USE(ROW_USE), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_low(ras_low), .cas_act(cas_act),
  .we_hi(we_hi), .oe_hi(oe_hi), .row_q(row_q), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
);

// File: tb/sim_edo_dram_ctl.sv
module sim_edo_dram_ctl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ras_ni = 1'b1, ucas_ni = 1'b1, lcas_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [15:0] dq_i = '0;
  logic [15:0] dq_o;
  logic [1:0]  dq_oe_o;

  int checks = 0;
  int fails = 0;
  logic [15:0] model [256];

  always #5 clk_i = ~clk_i;

  edo_dram_ctl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ras_ni(ras_ni), .ucas_ni(ucas_ni), .lcas_ni(lcas_ni),
    .we_ni(we_ni), .oe_ni(oe_ni), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // two sync stages plus decode and output register
  task automatic settle();
    repeat (5) @(negedge clk_i);
  endtask

  task automatic open_row(input int row);
    addr_i = 9'(row); settle();
    ras_ni = 1'b0; settle();
  endtask

  task automatic close_all();
    lcas_ni = 1'b1; ucas_ni = 1'b1; settle();
    we_ni = 1'b1; ras_ni = 1'b1; settle();
  endtask

  // write enable first, strobe fall captures
  task automatic wr_word(input int row, input int col, input logic [15:0] d, input logic [1:0] lanes);
    open_row(row);
    addr_i = 9'(col); dq_i = d; we_ni = 1'b0; settle();
    lcas_ni = ~lanes[0]; ucas_ni = ~lanes[1]; settle();
    close_all();
    if (lanes[0]) model[row*16+col][7:0]  = d[7:0];
    if (lanes[1]) model[row*16+col][15:8] = d[15:8];
  endtask

  task automatic rd_word(input int row, input int col, output logic [15:0] d, output logic [1:0] oe);
    open_row(row);
    addr_i = 9'(col); lcas_ni = 1'b0; ucas_ni = 1'b0; settle();
    d = dq_o; oe = dq_oe_o;
    close_all();
  endtask

  task automatic t_reset();
    chk("R8 drive enable after reset", {14'b0, dq_oe_o}, 16'h0);
    chk("R8 data after reset", dq_o, 16'h0);
  endtask

  task automatic t_row_select();
    logic [15:0] d; logic [1:0] oe;
    wr_word(3, 7, 16'hA1B2, 2'b11);
    wr_word(9, 7, 16'h5C6D, 2'b11);
    rd_word(3, 7, d, oe);
    chk("R5 row 3 col 7", d, model[3*16+7]);
    chk("R6 both lanes drive on read", {14'b0, oe}, 16'h3);
    rd_word(9, 7, d, oe);
    chk("R5 row 9 col 7", d, model[9*16+7]);
  endtask

  task automatic t_lanes();
    logic [15:0] d; logic [1:0] oe;
    wr_word(4, 2, 16'h1111, 2'b11);
    wr_word(4, 2, 16'hEEDD, 2'b01);
    rd_word(4, 2, d, oe);
    chk("R2 low lane only write", d, 16'h11DD);
    wr_word(4, 2, 16'h7788, 2'b10);
    rd_word(4, 2, d, oe);
    chk("R2 high lane only write", d, 16'h77DD);
    open_row(4);
    addr_i = 9'd2; ucas_ni = 1'b0; settle();
    chk("R2 high strobe drives lane 1 only", {14'b0, dq_oe_o}, 16'h2);
    close_all();
  endtask

  task automatic t_capture();
    logic [15:0] d; logic [1:0] oe;
    // strobes first, write enable falls later
    open_row(5);
    addr_i = 9'd3; lcas_ni = 1'b0; ucas_ni = 1'b0; settle();
    dq_i = 16'hC0DE; we_ni = 1'b0; settle();
    dq_i = 16'hBAD0; settle();
    close_all();
    rd_word(5, 3, d, oe);
    chk("R3 capture at write enable fall", d, 16'hC0DE);
    // write enable first, strobe falls later
    open_row(5);
    addr_i = 9'd4; dq_i = 16'h2468; we_ni = 1'b0; settle();
    lcas_ni = 1'b0; ucas_ni = 1'b0; settle();
    dq_i = 16'hFFFF; settle();
    close_all();
    rd_word(5, 4, d, oe);
    chk("R3 capture at strobe fall", d, 16'h2468);
  endtask

  task automatic t_edo_and_off();
    wr_word(6, 1, 16'h4242, 2'b11);
    open_row(6);
    addr_i = 9'd1; lcas_ni = 1'b0; ucas_ni = 1'b0; settle();
    lcas_ni = 1'b1; ucas_ni = 1'b1; settle();
    chk("R4 data held in precharge", dq_o, 16'h4242);
    chk("R4 drive held in precharge", {14'b0, dq_oe_o}, 16'h3);
    oe_ni = 1'b1; settle();
    chk("R6 output enable high", {14'b0, dq_oe_o}, 16'h0);
    oe_ni = 1'b0; we_ni = 1'b0; settle();
    chk("R6 write enable low", {14'b0, dq_oe_o}, 16'h0);
    we_ni = 1'b1; settle();
    lcas_ni = 1'b0; ucas_ni = 1'b0; settle();
    lcas_ni = 1'b1; ucas_ni = 1'b1; ras_ni = 1'b1; settle();
    chk("R6 row and column strobes high", {14'b0, dq_oe_o}, 16'h0);
    oe_ni = 1'b1; settle(); oe_ni = 1'b0; settle();
    chk("R6 drive stays off after precharge", {14'b0, dq_oe_o}, 16'h0);
  endtask

  task automatic t_page();
    wr_word(2, 1, 16'h0101, 2'b11);
    wr_word(2, 5, 16'h0505, 2'b11);
    wr_word(2, 9, 16'h0909, 2'b11);
    open_row(2);
    for (int i = 0; i < 3; i++) begin
      addr_i = 9'(1 + 4*i); lcas_ni = 1'b0; ucas_ni = 1'b0; settle();
      chk("R7 page access", dq_o, model[2*16 + 1 + 4*i]);
      lcas_ni = 1'b1; ucas_ni = 1'b1; settle();
    end
    close_all();
  endtask

  task automatic t_merge();
    open_row(2);
    addr_i = 9'd1; lcas_ni = 1'b0; settle();
    chk("R2 low strobe drives lane 0 only", {14'b0, dq_oe_o}, 16'h1);
    addr_i = 9'd5; ucas_ni = 1'b0; settle();
    chk("R1 second strobe keeps first column", dq_o, model[2*16+1]);
    lcas_ni = 1'b1; settle();
    addr_i = 9'd9; lcas_ni = 1'b0; settle();
    chk("R1 toggle under held strobe keeps column", dq_o, model[2*16+1]);
    lcas_ni = 1'b1; ucas_ni = 1'b1; settle();
    lcas_ni = 1'b0; settle();
    chk("R1 new column after both strobes rose", dq_o, model[2*16+9]);
    close_all();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    settle();
    t_row_select();
    t_lanes();
    t_capture();
    t_edo_and_off();
    t_page();
    t_merge();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule